// File: doc/BRIEF.md
# Powerdown and Clock-Loss Supervisor

This block decides when the codec core sits in its low-power state and what the two control registers must be forced to while it does. After power-on it keeps the core in a forced hold for a fixed number of master-clock rising edges. It also watches the master clock from an independent, free-running reference clock. If the master clock stays high for longer than a set time, the block declares clock loss and enters the same forced hold. When the clock toggles again, the start-up hold runs a second time.

Two requests from outside the block can also power the core down. The first comes from the two function bits at the top of register A. The second comes from a control-word window received at the negative address level with every bit high. In both cases the serial output driver is disabled, but the six side outputs and the test-mode selector still follow register B. During a forced hold the side outputs are driven inactive, register B is cleared, and register A is loaded with its powerdown pattern.

Top module: `pwrdn_supervisor`

## Requirements
- R1: After `por_n` is released, `ctl_wr_lock` and `pwr_down` stay 1 through the 24th rising edge of `mclk` and fall at the 25th (INIT_CYCLES = 25).
- R2: While the forced hold is active (`ctl_wr_lock` = 1), `rega_force` and `regb_clear` are 1, `rega_force_val` is 8'hC0 (bits 7 and 6 set, bits 5..0 clear), and `side_out` and `test_sel` are 0 whatever `reg_b_q` holds.
- R3: A control window received during the forced hold has no effect: an all-ones window at the negative address sent during start-up does not leave `pwr_down` set once the hold ends.
- R4: When `mclk` stays high for LOSS_NS (default 20 us, measured on `ref_clk`), `pwr_down` and `ctl_wr_lock` go to 1 while the clock is still stopped.
- R5: A stall of `mclk` shorter than the threshold (5 us and 15 us are tested) does not raise `pwr_down`.
- R6: Once `mclk` toggles again after a clock loss, the forced hold stays active and is released only after a fresh count of INIT_CYCLES master-clock edges.
- R7: `pwr_down` and `out_disable` are 1 when both `reg_a_q[7]` and `reg_a_q[6]` are 1. They are 0 for the values 00, 01 and 10 of those two bits (when no other cause is present).
- R8: Outside the forced hold, `side_out` equals `reg_b_q[5:0]` (1 = active) and `test_sel` equals `reg_b_q[7:6]` (00 = normal). This holds even during a register-driven powerdown.
- R9: A window at the negative address (`ctl_addr` = 2'b00) with all 8 bits 1 sets powerdown from the edge that takes it. A later negative-address window with any bit 0 clears it.
- R10: Windows at the ground address (2'b01) or the positive address (2'b10) never set or clear the control-line powerdown, whatever their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; registers in this domain use its rising edge |
| ref_clk | input | 1 | Free-running reference clock used to time clock loss |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ctl_win_valid | input | 1 | One-cycle pulse: a full control window has been received |
| ctl_win_bits | input | 8 | The 8 bits of that control window |
| ctl_addr | input | 2 | Address level: 00 negative, 01 ground, 10 positive |
| reg_a_q | input | 8 | Current contents of register A |
| reg_b_q | input | 8 | Current contents of register B |
| pwr_down | output | 1 | Core is powered down |
| out_disable | output | 1 | Serial output driver disabled |
| ctl_wr_lock | output | 1 | Forced hold; control registers must not be written |
| rega_force | output | 1 | Load register A with `rega_force_val` |
| rega_force_val | output | 8 | Powerdown pattern for register A |
| regb_clear | output | 1 | Clear register B |
| side_out | output | 6 | Side output drives, 1 = active |
| test_sel | output | 2 | Test-mode selector, 00 = normal |

## Verification
The register-driven terms (R7, R8) are combinational, so the bench checks them 1 ns after it changes `reg_a_q` or `reg_b_q`. A control window is applied just after one rising edge and its result is read 1 ns after the next (R9, R10). The start-up count is checked edge by edge, at the 24th and 25th rising edges after release. Clock-loss results depend on two clock domains, so they are sampled at instants well clear of each uncertain span: 15 us and 25 us into a stall against a 20 us threshold, and 10 and 70 master cycles after the clock resumes against a release that lands about 36 cycles later.

// File: rtl/pwrdn_pkg.sv
`timescale 1ns/1ps
package pwrdn_pkg;

  typedef enum logic [1:0] {
    ADDR_NEG = 2'b00,
    ADDR_GND = 2'b01,
    ADDR_POS = 2'b10
  } ctl_addr_e;

  localparam int CTRL_W = 8;

  // pattern register A takes while the forced hold is active
  function automatic logic [CTRL_W-1:0] held_rega_value();
    return {2'b11, {(CTRL_W-2){1'b0}}};
  endfunction

  // register A function field requests powerdown when both bits are set
  function automatic logic rega_requests_pd(input logic [CTRL_W-1:0] a);
    return a[CTRL_W-1] & a[CTRL_W-2];
  endfunction

  // control line counts as held high only when every window bit is one
  function automatic logic window_all_high(input logic [CTRL_W-1:0] w);
    return &w;
  endfunction

  // reference-clock cycles that span a given time
  function automatic int span_in_ref_cycles(input int ref_mhz, input int span_ns);
    return (ref_mhz * span_ns) / 1000;
  endfunction

endpackage

// File: rtl/pwrdn_init_timer.sv
`timescale 1ns/1ps
module pwrdn_init_timer #(
  parameter int INIT_CYCLES = 25
) (
  input  logic mclk,
  input  logic por_n,
  input  logic restart,
  output logic hold
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_END = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign hold = (cnt_q != CNT_END);

  // R1
  init_release_chk: assert property (@(posedge mclk) disable iff (!por_n)
    $fell(hold) |-> ($past(cnt_q) == CNT_END - 1'b1));

  // R6
  init_restart_chk: assert property (@(posedge mclk) disable iff (!por_n)
    restart |=> hold);

endmodule

// File: rtl/pwrdn_clkloss_mon.sv
`timescale 1ns/1ps
module pwrdn_clkloss_mon #(
  parameter int LIMIT = 2000
) (
  input  logic ref_clk,
  input  logic por_n,
  input  logic mclk,
  output logic lost
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_END = CW'(LIMIT);

  logic mclk_s1, mclk_s2;
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      mclk_s1 <= 1'b0;
      mclk_s2 <= 1'b0;
    end else begin
      mclk_s1 <= mclk;
      mclk_s2 <= mclk_s1;
    end
  end

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n)                  hi_cnt_q <= '0;
    else if (!mclk_s2)           hi_cnt_q <= '0;
    else if (hi_cnt_q != CNT_END) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign lost = (hi_cnt_q == CNT_END);

  // R4
  loss_only_when_high_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(lost) |-> $past(mclk_s2));

  // R6
  loss_clears_on_toggle_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    !mclk_s2 |=> !lost);

endmodule

// File: rtl/pwrdn_req_merge.sv
`timescale 1ns/1ps
module pwrdn_req_merge
  import pwrdn_pkg::*;
(
  input  logic              mclk,
  input  logic              por_n,
  input  logic              hold,
  input  logic              win_valid,
  input  logic [CTRL_W-1:0] win_bits,
  input  logic [1:0]        win_addr,
  output logic              line_pd
);
  logic neg_window;
  assign neg_window = win_valid && (win_addr == ADDR_NEG);

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n)          line_pd <= 1'b0;
    else if (hold)       line_pd <= 1'b0;
    else if (neg_window) line_pd <= window_all_high(win_bits);
  end

  // R9
  neg_window_sets_chk: assert property (@(posedge mclk) disable iff (!por_n)
    (neg_window && !hold) |=> (line_pd == $past(&win_bits)));

  // R10
  other_addr_ignored_chk: assert property (@(posedge mclk) disable iff (!por_n)
    (win_valid && (win_addr != ADDR_NEG) && !hold) |=> (line_pd == $past(line_pd)));

  // R3
  hold_blocks_line_chk: assert property (@(posedge mclk) disable iff (!por_n)
    hold |=> !line_pd);

endmodule

// File: rtl/pwrdn_supervisor.sv
`timescale 1ns/1ps
module pwrdn_supervisor
  import pwrdn_pkg::*;
#(
  parameter int INIT_CYCLES = 25,
  parameter int REF_MHZ     = 100,
  parameter int LOSS_NS     = 20000
) (
  input  logic       mclk,
  input  logic       ref_clk,
  input  logic       por_n,
  input  logic       ctl_win_valid,
  input  logic [7:0] ctl_win_bits,
  input  logic [1:0] ctl_addr,
  input  logic [7:0] reg_a_q,
  input  logic [7:0] reg_b_q,
  output logic       pwr_down,
  output logic       out_disable,
  output logic       ctl_wr_lock,
  output logic       rega_force,
  output logic [7:0] rega_force_val,
  output logic       regb_clear,
  output logic [5:0] side_out,
  output logic [1:0] test_sel
);
  localparam int LOSS_LIMIT = span_in_ref_cycles(REF_MHZ, LOSS_NS);

  // named internal events
  logic clk_lost;      // reference-domain loss flag
  logic loss_m1, loss_m2; // loss flag seen in master domain
  logic init_hold;
  logic hold_m;        // master-domain forced hold
  logic force_hold;    // forced hold, either domain
  logic line_pd;
  logic reg_pd;

  pwrdn_clkloss_mon #(.LIMIT(LOSS_LIMIT)) u_loss (
    .ref_clk (ref_clk),
    .por_n   (por_n),
    .mclk    (mclk),
    .lost    (clk_lost)
  );

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n) begin
      loss_m1 <= 1'b0;
      loss_m2 <= 1'b0;
    end else begin
      loss_m1 <= clk_lost;
      loss_m2 <= loss_m1;
    end
  end

  pwrdn_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .mclk    (mclk),
    .por_n   (por_n),
    .restart (loss_m2),
    .hold    (init_hold)
  );

  assign hold_m     = init_hold | loss_m2;
  assign force_hold = hold_m | clk_lost;

  pwrdn_req_merge u_merge (
    .mclk      (mclk),
    .por_n     (por_n),
    .hold      (hold_m),
    .win_valid (ctl_win_valid),
    .win_bits  (ctl_win_bits),
    .win_addr  (ctl_addr),
    .line_pd   (line_pd)
  );

  assign reg_pd = rega_requests_pd(reg_a_q);

  assign pwr_down       = force_hold | reg_pd | line_pd;
  assign out_disable    = pwr_down;
  assign ctl_wr_lock    = force_hold;
  assign rega_force     = force_hold;
  assign rega_force_val = held_rega_value();
  assign regb_clear     = force_hold;
  assign side_out       = force_hold ? 6'd0 : reg_b_q[5:0];
  assign test_sel       = force_hold ? 2'd0 : reg_b_q[7:6];

  // R2
  forced_state_chk: assert property (@(posedge mclk) disable iff (!por_n)
    ctl_wr_lock |-> (rega_force && regb_clear && rega_force_val == 8'hC0 &&
                     side_out == 6'd0 && test_sel == 2'd0 && pwr_down));

  // R7
  rega_pd_chk: assert property (@(posedge mclk) disable iff (!por_n)
    (reg_a_q[7] && reg_a_q[6]) |-> (pwr_down && out_disable));

  // R8
  side_follow_chk: assert property (@(posedge mclk) disable iff (!por_n)
    !ctl_wr_lock |-> (side_out == reg_b_q[5:0] && test_sel == reg_b_q[7:6]));

endmodule

// File: tb/pwrdn_supervisor_bench.sv
`timescale 1ns/1ps
module pwrdn_supervisor_bench;

  logic       mclk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       run = 1'b1;
  logic       por_n = 1'b0;
  logic       ctl_win_valid = 1'b0;
  logic [7:0] ctl_win_bits = 8'h00;
  logic [1:0] ctl_addr = 2'b00;
  logic [7:0] reg_a_q = 8'h00;
  logic [7:0] reg_b_q = 8'hFF;
  logic       pwr_down, out_disable, ctl_wr_lock, rega_force, regb_clear;
  logic [7:0] rega_force_val;
  logic [5:0] side_out;
  logic [1:0] test_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // 250 MHz master clock; it parks high when run is low
  always #2 mclk = run ? ~mclk : 1'b1;
  always #5 ref_clk = ~ref_clk;

  pwrdn_supervisor u_pwrdn_supervisor (
    .mclk(mclk), .ref_clk(ref_clk), .por_n(por_n),
    .ctl_win_valid(ctl_win_valid), .ctl_win_bits(ctl_win_bits), .ctl_addr(ctl_addr),
    .reg_a_q(reg_a_q), .reg_b_q(reg_b_q),
    .pwr_down(pwr_down), .out_disable(out_disable), .ctl_wr_lock(ctl_wr_lock),
    .rega_force(rega_force), .rega_force_val(rega_force_val), .regb_clear(regb_clear),
    .side_out(side_out), .test_sel(test_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge mclk);
      #1;
    end
  endtask

  task automatic send_win(input logic [1:0] addr, input logic [7:0] bits);
    ctl_win_valid = 1'b1;
    ctl_addr      = addr;
    ctl_win_bits  = bits;
    tick(1);
    ctl_win_valid = 1'b0;
  endtask

  // {reg_a, reg_b, pwr_down, side_out, test_sel}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 6'h00, 2'd0},
    {8'hC0, 8'h2A, 1'b1, 6'h2A, 2'd0},
    {8'h80, 8'h15, 1'b0, 6'h15, 2'd0},
    {8'h40, 8'hC3, 1'b0, 6'h03, 2'd3},
    {8'hFF, 8'h7F, 1'b1, 6'h3F, 2'd1},
    {8'h3F, 8'h80, 1'b0, 6'h00, 2'd2}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state: R2
    #9;
    check("R2 lock in reset", ctl_wr_lock, 1);
    check("R2 side cleared", side_out, 0);
    check("R2 rega value", rega_force_val, 8'hC0);
    check("R2 regb clear", regb_clear, 1);
    check("R2 rega force", rega_force, 1);
    @(posedge mclk); #1;
    por_n = 1'b1;
    // R1 start-up count, R3 window during hold
    for (int k = 1; k <= 25; k++) begin
      if (k == 4) begin
        ctl_win_valid = 1'b1; ctl_addr = 2'b00; ctl_win_bits = 8'hFF;
      end
      @(posedge mclk); #1;
      if (k == 4) ctl_win_valid = 1'b0;
      if (k == 1)  check("R1 hold at edge 1", ctl_wr_lock, 1);
      if (k == 24) check("R1 hold at edge 24", ctl_wr_lock, 1);
      if (k == 25) check("R1 released at edge 25", ctl_wr_lock, 0);
    end
    check("R3 window in hold ignored", pwr_down, 0);
    check("R8 side after release", side_out, 6'h3F);

    // R7, R8 vector walk
    for (int v = 0; v < NV; v++) begin
      reg_a_q = VEC[v][24:17];
      reg_b_q = VEC[v][16:9];
      #1;
      check("R7 reg powerdown", pwr_down, VEC[v][8]);
      check("R7 out disable", out_disable, VEC[v][8]);
      check("R8 side follow", side_out, VEC[v][7:2]);
      check("R8 test select", test_sel, VEC[v][1:0]);
    end
    reg_a_q = 8'h00;
    reg_b_q = 8'h00;

    // R9, R10 control-line powerdown
    send_win(2'b00, 8'hFF);
    check("R9 neg all-ones sets", pwr_down, 1);
    send_win(2'b01, 8'h00);
    check("R10 gnd window keeps", pwr_down, 1);
    send_win(2'b10, 8'h00);
    check("R10 pos window keeps", pwr_down, 1);
    send_win(2'b00, 8'h7F);
    check("R9 neg zero bit clears", pwr_down, 0);
    send_win(2'b01, 8'hFF);
    check("R10 gnd all-ones ignored", pwr_down, 0);
    send_win(2'b10, 8'hFF);
    check("R10 pos all-ones ignored", pwr_down, 0);

    // R5 short stall
    reg_b_q = 8'hFF;
    run = 1'b0;
    #5000;
    check("R5 5us stall no loss", pwr_down, 0);
    run = 1'b1;
    tick(20);
    check("R5 after short stall", ctl_wr_lock, 0);

    // R4 clock loss, R6 resume
    run = 1'b0;
    #15000;
    check("R5 15us stall no loss", pwr_down, 0);
    #10000;
    check("R4 loss powerdown", pwr_down, 1);
    check("R4 loss lock", ctl_wr_lock, 1);
    check("R2 side cleared on loss", side_out, 0);
    run = 1'b1;
    tick(10);
    check("R6 hold after resume", ctl_wr_lock, 1);
    tick(60);
    check("R6 released after recount", ctl_wr_lock, 0);
    check("R6 powerdown cleared", pwr_down, 0);
    check("R8 side restored", side_out, 6'h3F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule